// File: doc/BRIEF.md
# Multichannel Stimulation Switch Sequencer

This block sequences the five switches of a single capacitor-coupled stimulator output stage and steers the stimulus to one of several electrode channels, one channel per frame. Each frame opens with an active cathodic interval. In that interval the fast switching clock is chopped into two alternating charge paths, with a dead cycle between them, and their summed currents form one long cathodic pulse. An idle interphase gap follows, then a passive-discharge interval that fills the rest of the frame. The next frame starts right after it, on the next enabled channel.

All durations are programmed in fast-clock cycles, so the same logic works for any switching clock from 1 MHz to 20 MHz. For example, at 10 MHz the settings 1500 / 1500 / 500000 give a 150 µs cathodic interval, a 150 µs gap and a 50 ms frame (20 Hz). The 8-bit amplitude code, bit 0 least significant, is captured for the external current generator at the start of each frame. The analog current generator, diodes, capacitors and loads sit outside this block.

Top module: `stim_seq_top`

## Requirements
- R1: While reset is held, and on the first cycle after it, all five switch outputs are 0, `ch_sel` is 0 and `amp_out` is 0.
- R2: In cycle k of the cathodic interval (k counted from 0 at its first cycle), k mod 4 = 0 closes S1 and S4 only, k mod 4 = 2 closes S2 and S3 only, and odd k opens all five switches (dead cycle).
- R3: S1 and S2 are never closed in the same cycle, and a cycle with one of them closed is never directly followed by a cycle with the other closed.
- R4: The cathodic interval lasts max(`cath_len`,1) cycles. It is followed by an interphase gap of max(`gap_len`,1) cycles in which all five switches are open.
- R5: After the gap, only SL is closed (passive discharge). This lasts until the frame has run `frame_len` cycles counted from its first cathodic cycle, and always for at least one cycle.
- R6: When `enable` is 1 and `ch_mask` is nonzero at the last discharge cycle, the next frame's first cathodic cycle follows immediately.
- R7: Channels are served in ascending index order after the last served channel, wrapping around. Channels whose `ch_mask` bit is 0 are skipped without spending a frame. After reset the lowest enabled channel is served first.
- R8: `amp_out` and `ch_sel` are captured at the first cathodic cycle and held for the whole frame, whatever `amp_code` or `ch_mask` do meanwhile.
- R9: `ch_sel` is one-hot during a frame and 0 when idle. Deasserting `enable` takes effect only at the frame boundary: the running frame completes, then all switches stay open and `ch_sel` returns to 0.
- R10: With `enable` at 1 but `ch_mask` all zero, no frame starts and all outputs stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast switching clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allow new frames to start |
| amp_code | input | 8 | Stimulus amplitude code, bit 0 is LSB |
| cath_len | input | 20 | Cathodic interval length in cycles |
| gap_len | input | 20 | Interphase gap length in cycles |
| frame_len | input | 20 | Total frame length in cycles |
| ch_mask | input | 8 | Per-channel enable mask, bit i for channel i |
| sw_s1 | output | 1 | Switch S1 control, 1 = closed |
| sw_s2 | output | 1 | Switch S2 control, 1 = closed |
| sw_s3 | output | 1 | Switch S3 control, 1 = closed |
| sw_s4 | output | 1 | Switch S4 control, 1 = closed |
| sw_sl | output | 1 | Load discharge switch control, 1 = closed |
| ch_sel | output | 8 | One-hot channel select for the demultiplexer |
| amp_out | output | 8 | Amplitude code held for the current generator |

## Verification
On every cycle the assertions check the switch-safety rules: S1 and S2 never overlap or follow each other back to back, switches are closed only in pairs, SL is only ever closed alone, any closed switch comes with a one-hot channel, and amplitude and channel stay frozen inside a frame. Only the directed scenarios can show the timing: the exact chop pattern against the cycle index, the gap and discharge lengths including the zero-length and short-frame corners, the ascending wrap-around channel order with masked channels skipped, back-to-back frames, and a clean stop at the frame boundary.

// File: rtl/stim_seq_pkg.sv
// Shared types for the stimulation switch sequencer.
// Assumes: switch outputs are active-high (1 = switch closed).
package stim_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CATH = 2'd1,
        ST_GAP  = 2'd2,
        ST_DIS  = 2'd3
    } stim_state_e;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic s4;
        logic sl;
    } sw_ctrl_t;

    localparam sw_ctrl_t SW_ALL_OPEN = '{s1: 1'b0, s2: 1'b0, s3: 1'b0, s4: 1'b0, sl: 1'b0};

endpackage

// File: rtl/stim_interval_fsm.sv
// Frame interval sequencer: IDLE -> CATH -> GAP -> DIS -> (CATH | IDLE).
// Counts the cathodic and gap intervals and the whole-frame length in
// fast-clock cycles. A zero length is treated as one cycle. Discharge lasts
// until the frame has run frame_len cycles, and at least one cycle.
// Assumes: lengths are held stable by the user while a frame runs.
module stim_interval_fsm
    import stim_seq_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CNT_W-1:0]  cath_len,
    input  logic [CNT_W-1:0]  gap_len,
    input  logic [CNT_W-1:0]  frame_len,
    output stim_state_e       state_o,
    output logic [1:0]        chop_o,
    output logic              frame_start_o,
    output logic              frame_end_o
);

    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    stim_state_e      state_q, state_d;
    logic [CNT_W-1:0] ivl_cnt_q;
    logic [CNT_W-1:0] frm_cnt_q;
    logic [CNT_W-1:0] cath_eff, gap_eff;
    logic             cath_last, gap_last, dis_done;

    // Effective interval lengths with the one-cycle minimum applied.
    always_comb begin
        cath_eff  = (cath_len == '0) ? ONE : cath_len;
        gap_eff   = (gap_len  == '0) ? ONE : gap_len;
        cath_last = (ivl_cnt_q == cath_eff - ONE);
        gap_last  = (ivl_cnt_q == gap_eff - ONE);
        dis_done  = ({1'b0, frm_cnt_q} + {1'b0, ONE}) >= {1'b0, frame_len};
    end

    // Next-state selection and frame boundary strobes.
    always_comb begin
        state_d       = state_q;
        frame_start_o = 1'b0;
        frame_end_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    state_d       = ST_CATH;
                    frame_start_o = 1'b1;
                end
            end
            ST_CATH: if (cath_last) state_d = ST_GAP;
            ST_GAP:  if (gap_last)  state_d = ST_DIS;
            ST_DIS: begin
                if (dis_done) begin
                    if (go) begin
                        state_d       = ST_CATH;
                        frame_start_o = 1'b1;
                    end else begin
                        state_d     = ST_IDLE;
                        frame_end_o = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Interval counter: restarts on every state change, runs in CATH and GAP.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         ivl_cnt_q <= '0;
        else if (state_d != state_q || frame_start_o)       ivl_cnt_q <= '0;
        else if (state_q == ST_CATH || state_q == ST_GAP)   ivl_cnt_q <= ivl_cnt_q + ONE;
        else                                                ivl_cnt_q <= '0;
    end

    // Frame counter: zero at the first cathodic cycle, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         frm_cnt_q <= '0;
        else if (frame_start_o)                             frm_cnt_q <= '0;
        else if (state_q != ST_IDLE && frm_cnt_q != CNT_MAX) frm_cnt_q <= frm_cnt_q + ONE;
    end

    assign state_o = state_q;
    assign chop_o  = ivl_cnt_q[1:0];

endmodule

// File: rtl/stim_chan_pick.sv
// Channel arbiter: on each frame start picks the next enabled channel in
// ascending order after the last served one, wrapping around, and holds its
// one-hot select until the sequencer returns to idle.
// Assumes: frame_start is only raised when the mask has a bit set.
module stim_chan_pick #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] mask,
    input  logic              frame_start,
    input  logic              frame_end,
    output logic [NUM_CH-1:0] ch_sel_o
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [IDX_W-1:0]  last_q;
    logic [IDX_W-1:0]  pick_idx;
    logic              found;
    int                cand;

    // Search forward from the last served channel for the first enabled one.
    always_comb begin
        pick_idx = last_q;
        found    = 1'b0;
        cand     = 0;
        for (int off = 1; off <= NUM_CH; off++) begin
            cand = (int'(last_q) + off) % NUM_CH;
            if (!found && mask[cand]) begin
                found    = 1'b1;
                pick_idx = IDX_W'(cand);
            end
        end
    end

    // Last served index; starts at the top so the lowest channel goes first.
    always_ff @(posedge clk) begin
        if (!rst_n)                    last_q <= IDX_W'(NUM_CH - 1);
        else if (frame_start && found) last_q <= pick_idx;
    end

    // One-hot select, held for a whole frame and cleared on the way to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ch_sel_o <= '0;
        else if (frame_start && found) ch_sel_o <= NUM_CH'(1) << pick_idx;
        else if (frame_end)            ch_sel_o <= '0;
    end

endmodule

// File: rtl/stim_sw_decode.sv
// Switch pattern decoder: maps interval state and chop phase to the five
// switch controls. Chop phase 0 drives path A (S1,S4), phase 2 drives path B
// (S2,S3), odd phases are dead cycles with every switch open.
// Assumes: inputs come straight from registers, so outputs are glitch-light.
module stim_sw_decode
    import stim_seq_pkg::*;
(
    input  stim_state_e state,
    input  logic [1:0]  chop,
    output sw_ctrl_t    sw_o
);

    // Pure decode of the switch pattern for the current cycle.
    always_comb begin
        sw_o = SW_ALL_OPEN;
        unique case (state)
            ST_CATH: begin
                if (chop == 2'd0) begin
                    sw_o.s1 = 1'b1;
                    sw_o.s4 = 1'b1;
                end else if (chop == 2'd2) begin
                    sw_o.s2 = 1'b1;
                    sw_o.s3 = 1'b1;
                end
            end
            ST_DIS:  sw_o.sl = 1'b1;
            default: sw_o = SW_ALL_OPEN;
        endcase
    end

endmodule

// File: rtl/stim_seq_top.sv
// Top of the stimulation switch sequencer. Ties the interval sequencer, the
// channel arbiter and the switch decoder together and holds the amplitude
// code for the current generator for the length of each frame.
// Assumes: a single clock domain (the fast switching clock).
module stim_seq_top
    import stim_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int AMP_W  = 8,
    parameter int CNT_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [AMP_W-1:0]  amp_code,
    input  logic [CNT_W-1:0]  cath_len,
    input  logic [CNT_W-1:0]  gap_len,
    input  logic [CNT_W-1:0]  frame_len,
    input  logic [NUM_CH-1:0] ch_mask,
    output logic              sw_s1,
    output logic              sw_s2,
    output logic              sw_s3,
    output logic              sw_s4,
    output logic              sw_sl,
    output logic [NUM_CH-1:0] ch_sel,
    output logic [AMP_W-1:0]  amp_out
);

    stim_state_e      state;
    logic [1:0]       chop;
    logic             frame_start, frame_end;
    logic             go;
    sw_ctrl_t         sw;
    logic [AMP_W-1:0] amp_q;

    // A frame may start only when enabled and at least one channel is on.
    assign go = enable && (ch_mask != '0);

    stim_interval_fsm #(
        .CNT_W (CNT_W)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (go),
        .cath_len      (cath_len),
        .gap_len       (gap_len),
        .frame_len     (frame_len),
        .state_o       (state),
        .chop_o        (chop),
        .frame_start_o (frame_start),
        .frame_end_o   (frame_end)
    );

    stim_chan_pick #(
        .NUM_CH (NUM_CH)
    ) pick_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask        (ch_mask),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .ch_sel_o    (ch_sel)
    );

    stim_sw_decode dec_i (
        .state (state),
        .chop  (chop),
        .sw_o  (sw)
    );

    // Amplitude hold register, loaded only at the first cathodic cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)           amp_q <= '0;
        else if (frame_start) amp_q <= amp_code;
    end

    assign amp_out = amp_q;
    assign sw_s1   = sw.s1;
    assign sw_s2   = sw.s2;
    assign sw_s3   = sw.s3;
    assign sw_s4   = sw.s4;
    assign sw_sl   = sw.sl;

endmodule

// File: rtl/stim_seq_checker.sv
// Safety checker for the stimulation switch sequencer, bound to the top.
// Watches only the top-level ports.
module stim_seq_checker #(
    parameter int NUM_CH = 8,
    parameter int AMP_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_s1,
    input logic              sw_s2,
    input logic              sw_s3,
    input logic              sw_s4,
    input logic              sw_sl,
    input logic [NUM_CH-1:0] ch_sel,
    input logic [AMP_W-1:0]  amp_out
);

    // R3: the two charge paths never conduct together.
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_s1 && sw_s2));

    // R3: a dead cycle separates path A from path B.
    a_r3_dead_a_to_b: assert property (@(posedge clk) disable iff (!rst_n)
        sw_s1 |=> !sw_s2);

    // R3: a dead cycle separates path B from path A.
    a_r3_dead_b_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        sw_s2 |=> !sw_s1);

    // R2: switches close only in their fixed pairs.
    a_r2_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_s1 == sw_s4) && (sw_s2 == sw_s3));

    // R5: the discharge switch is only ever closed alone.
    a_r5_sl_alone: assert property (@(posedge clk) disable iff (!rst_n)
        sw_sl |-> !(sw_s1 || sw_s2 || sw_s3 || sw_s4));

    // R9: channel select is one-hot or zero.
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_sel));

    // R9: no switch closes without a selected channel.
    a_r9_switch_needs_ch: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_s1 || sw_s2 || sw_s3 || sw_s4 || sw_sl) |-> (ch_sel != '0));

    // R8: amplitude and channel only change at a frame boundary.
    a_r8_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ch_sel) != '0 && ch_sel != '0 && !($past(sw_sl) && sw_s1))
        |-> ($stable(amp_out) && $stable(ch_sel)));

endmodule

bind stim_seq_top stim_seq_checker #(
    .NUM_CH (NUM_CH),
    .AMP_W  (AMP_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_s1   (sw_s1),
    .sw_s2   (sw_s2),
    .sw_s3   (sw_s3),
    .sw_s4   (sw_s4),
    .sw_sl   (sw_sl),
    .ch_sel  (ch_sel),
    .amp_out (amp_out)
);

// File: tb/stim_seq_top_tb_top.sv
// Directed bench for the stimulation switch sequencer.
// Inputs are driven and outputs sampled on the falling clock edge.
module stim_seq_top_tb_top;

    localparam int NUM_CH = 8;
    localparam int AMP_W  = 8;
    localparam int CNT_W  = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic [AMP_W-1:0]  amp_code = '0;
    logic [CNT_W-1:0]  cath_len = '0;
    logic [CNT_W-1:0]  gap_len = '0;
    logic [CNT_W-1:0]  frame_len = '0;
    logic [NUM_CH-1:0] ch_mask = '0;
    logic              sw_s1, sw_s2, sw_s3, sw_s4, sw_sl;
    logic [NUM_CH-1:0] ch_sel;
    logic [AMP_W-1:0]  amp_out;

    int checks = 0;
    int errors = 0;
    int last_ch = NUM_CH - 1;

    always #5 clk = ~clk;

    stim_seq_top #(
        .NUM_CH (NUM_CH),
        .AMP_W  (AMP_W),
        .CNT_W  (CNT_W)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .amp_code  (amp_code),
        .cath_len  (cath_len),
        .gap_len   (gap_len),
        .frame_len (frame_len),
        .ch_mask   (ch_mask),
        .sw_s1     (sw_s1),
        .sw_s2     (sw_s2),
        .sw_s3     (sw_s3),
        .sw_s4     (sw_s4),
        .sw_sl     (sw_sl),
        .ch_sel    (ch_sel),
        .amp_out   (amp_out)
    );

    function automatic logic [4:0] sw_now();
        return {sw_s1, sw_s2, sw_s3, sw_s4, sw_sl};
    endfunction

    // Expected {s1,s2,s3,s4,sl} for cycle i of a frame (R2, R4, R5).
    function automatic logic [4:0] exp_sw(int i, int ce, int ge);
        if (i < ce) begin
            case (i % 4)
                0:       return 5'b10010;
                2:       return 5'b01100;
                default: return 5'b00000;
            endcase
        end
        if (i < ce + ge) return 5'b00000;
        return 5'b00001;
    endfunction

    // Next channel in ascending order after 'last', skipping masked ones (R7).
    function automatic int next_ch(logic [NUM_CH-1:0] m, int last);
        for (int off = 1; off <= NUM_CH; off++) begin
            if (m[(last + off) % NUM_CH]) return (last + off) % NUM_CH;
        end
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Wait for the first cathodic cycle of a frame (S1 closed).
    task automatic wait_start(input string req);
        int n = 0;
        while (!sw_s1 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(sw_s1 == 1'b1, req, "frame start seen", int'(sw_s1), 1);
    endtask

    // Check one frame cycle by cycle from its first cathodic cycle; ends on
    // the cycle right after the frame. Optionally changes amp_code mid-frame.
    task automatic frame_check(input int ch, input logic [AMP_W-1:0] amp,
                               input int cl, input int gl, input int fl,
                               input logic [AMP_W-1:0] new_amp, input string req);
        int ce = (cl == 0) ? 1 : cl;
        int ge = (gl == 0) ? 1 : gl;
        int len = (fl > ce + ge + 1) ? fl : ce + ge + 1;
        int bad = 0;
        int bad_i = 0;
        logic [4:0] act_sw = '0;
        logic [4:0] want_sw = '0;
        logic [NUM_CH-1:0] act_ch = '0;
        logic [AMP_W-1:0] act_amp = '0;
        for (int i = 0; i < len; i++) begin
            if (i == 1) amp_code = new_amp;
            if (bad == 0 && (sw_now() != exp_sw(i, ce, ge) ||
                ch_sel != (NUM_CH'(1) << ch) || amp_out != amp)) begin
                bad = 1;
                bad_i = i;
                act_sw = sw_now();
                want_sw = exp_sw(i, ce, ge);
                act_ch = ch_sel;
                act_amp = amp_out;
            end
            @(negedge clk);
        end
        check(bad == 0, req, $sformatf("frame cycle %0d switches", bad_i),
              int'(act_sw), int'(want_sw));
        check(bad == 0, req, $sformatf("frame cycle %0d ch_sel/amp", bad_i),
              int'({act_ch, act_amp}), int'({NUM_CH'(1) << ch, amp}));
        last_ch = ch;
    endtask

    task automatic go_idle();
        int n = 0;
        enable = 1'b0;
        while (ch_sel != '0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(sw_now() == 5'b0 && ch_sel == '0 && amp_out == '0, "R1",
              "outputs during reset", int'({sw_now(), ch_sel}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sw_now() == 5'b0 && ch_sel == '0 && amp_out == '0, "R1",
              "outputs after reset", int'({sw_now(), ch_sel}), 0);
    endtask

    // R10: enabled with an empty mask never starts a frame.
    task automatic t_mask_zero();
        int seen = 0;
        ch_mask = '0;
        enable = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (sw_now() != 5'b0 || ch_sel != '0) seen++;
        end
        check(seen == 0, "R10", "cycles with activity and empty mask", seen, 0);
        enable = 1'b0;
        @(negedge clk);
    endtask

    // R2 R4 R5 R6 R8 R9: one channel, back-to-back frames, then a clean stop.
    task automatic t_single();
        int ch;
        cath_len = 6; gap_len = 3; frame_len = 16;
        ch_mask = 8'b0000_0100;
        amp_code = 8'hA5;
        ch = next_ch(ch_mask, last_ch);
        check(ch == 2, "R7", "first channel after reset is lowest enabled", ch, 2);
        enable = 1'b1;
        wait_start("R6");
        frame_check(ch, 8'hA5, 6, 3, 16, 8'h3C, "R2 R4 R5 R8");
        check(sw_s1 == 1'b1 && ch_sel == 8'b0000_0100, "R6",
              "next frame starts right after discharge", int'({sw_s1, ch_sel}),
              int'({1'b1, 8'b0000_0100}));
        enable = 1'b0;
        frame_check(ch, 8'h3C, 6, 3, 16, 8'h3C, "R9 running frame completes");
        check(sw_now() == 5'b0 && ch_sel == '0 && amp_out == 8'h3C, "R9",
              "idle after stop", int'({sw_now(), ch_sel}), 0);
        repeat (10) @(negedge clk);
        check(sw_now() == 5'b0 && ch_sel == '0, "R9", "stays idle",
              int'({sw_now(), ch_sel}), 0);
    endtask

    // R7 R8: ascending wrap-around order with masked channels skipped.
    task automatic t_round_robin();
        logic [AMP_W-1:0] amp = 8'h11;
        int ch;
        cath_len = 5; gap_len = 2; frame_len = 12;
        ch_mask = 8'b1001_0010;
        amp_code = amp;
        enable = 1'b1;
        wait_start("R7");
        for (int f = 0; f < 4; f++) begin
            ch = next_ch(ch_mask, last_ch);
            check(ch_sel == (NUM_CH'(1) << ch), "R7", "channel order",
                  int'(ch_sel), int'(NUM_CH'(1) << ch));
            if (f == 3) enable = 1'b0;
            frame_check(ch, amp, 5, 2, 12, amp + 8'h22, "R7 R8");
            amp = amp + 8'h22;
        end
        go_idle();
    endtask

    // R4 R5: zero lengths and a frame shorter than cathode plus gap.
    task automatic t_short();
        int ch;
        cath_len = 0; gap_len = 0; frame_len = 0;
        ch_mask = 8'b0000_0001;
        amp_code = 8'hFF;
        enable = 1'b1;
        ch = next_ch(ch_mask, last_ch);
        wait_start("R4");
        frame_check(ch, 8'hFF, 0, 0, 0, 8'h80, "R4 R5 zero lengths");
        cath_len = 6; gap_len = 3; frame_len = 4;
        enable = 1'b0;
        check(sw_s1 == 1'b1 && amp_out == 8'h80, "R6", "restart after short frame",
              int'({sw_s1, amp_out}), int'({1'b1, 8'h80}));
        frame_check(ch, 8'h80, 6, 3, 4, 8'h80, "R5 one discharge cycle minimum");
        go_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run timed out", 0, 1);
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_mask_zero();
        t_single();
        t_round_robin();
        t_short();
        finish_run();
    end

endmodule